// File: doc/BRIEF.md
# Credit-Gated DRAM Channel Arbiter

This block lets several cache sub-partitions share a single DRAM channel. Every sub-partition presents the status of its outbound request queue and its inbound response queue. Each cycle the arbiter picks at most one requester in rotating order and moves its request into a fixed-latency delay line. The delay line feeds the DRAM push port. Responses that appear at the head of the DRAM return queue are steered back to the sub-partition they came from.

Admission is limited by credits held in two tiers. Each sub-partition owns one private credit. A shared pool covers everything beyond that, and its size comes from the scheduler and return queue depths. A requester takes a credit when it is granted. Ordinary responses give the credit back when they enter the response queue. Writeback responses are retired directly and return no credit. DRAM timing itself is outside this block.

Top module: `dram_share_arb`

## Requirements
- R1: After reset the delay line is empty, no credit is held, and the last-borrower pointer is N_SUB-1, so the first round-robin search begins at sub-partition 0.
- R2: A sub-partition whose private credit is free always has credit.
- R3: The shared pool limit is SCHED_DEPTH + RETQ_DEPTH - (N_SUB-1). If either depth is 0, or the limit works out to 0, the pool is unlimited. A sub-partition whose private credit is in use has credit only while the shared count is below the limit.
- R4: A grant consumes the private credit of the granted sub-partition if it is free, and otherwise one shared credit. The granted sub-partition becomes the last borrower.
- R5: A credit return clears the private credit if it is held, and otherwise decrements the shared count. A return is applied before that cycle's eligibility is evaluated.
- R6: The search visits sub-partitions in increasing index order, wrapping around, starting one past the last borrower. req_pop is zero or one-hot.
- R7: No grant is made while dram_full is 1, or while the delay line already holds DLY_DEPTH entries.
- R8: A sub-partition is eligible only when req_nempty is 1, it has credit, and its rsp_full is 0.
- R9: A request granted in cycle t is offered on dram_push in the first cycle at or after t+LAT in which dram_full is 0. Requests leave in grant order. dram_gid is CHAN_ID*N_SUB plus the local index, and dram_data is the granted req_payload slice (slice i at bits i*PAY_W).
- R10: A valid return head is routed to local index ret_gid - CHAN_ID*N_SUB. It is popped only when that sub-partition's rsp_full is 0, and it is held otherwise.
- R11: A popped head with ret_wb=1 is retired without raising rsp_push and without returning credit. Any other popped head raises the one-hot rsp_push of its destination and returns a credit.
- R12: rsp_data carries ret_data on every push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_nempty | input | N_SUB | Request queue of each sub-partition holds an entry |
| req_payload | input | N_SUB*PAY_W | Head request of each sub-partition |
| req_pop | output | N_SUB | One-hot grant, pops the granted request queue |
| rsp_full | input | N_SUB | Response queue of each sub-partition is full |
| rsp_push | output | N_SUB | Push strobe into a response queue |
| rsp_data | output | PAY_W | Response payload |
| dram_full | input | 1 | DRAM cannot accept a request |
| dram_push | output | 1 | Delay line head moves into the DRAM |
| dram_gid | output | GID_W | Global sub-partition ID of the pushed request |
| dram_data | output | PAY_W | Payload of the pushed request |
| ret_valid | input | 1 | DRAM return queue head is valid |
| ret_gid | input | GID_W | Global sub-partition ID of the return head |
| ret_wb | input | 1 | Return head is a writeback |
| ret_data | input | PAY_W | Return head payload |
| ret_pop | output | 1 | Pops the DRAM return queue head |

## Verification
Some behaviours are checked on every cycle by assertions. These are the one-hot shape of the grant, the absence of grants and pushes while the DRAM is full, the eligibility conditions of a granted requester, and the hold-or-route decision for the return head, including the suppressed push for writebacks.

Other behaviours only show up over a run of cycles, so the bench's scenarios demonstrate them. These are the round-robin order after reset, credit exhaustion and refill through the private and shared tiers, and the exact delay-line exit cycle and order. An independent reference model follows the credits, the pointer and the delay line with absolute ready times.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  // Shared pool limit; 0 stands for "no limit".
  function automatic int shared_limit(int sched_depth, int retq_depth, int n_sub);
    if (sched_depth == 0 || retq_depth == 0) return 0;
    if (sched_depth + retq_depth - (n_sub - 1) < 0) return 0;
    return sched_depth + retq_depth - (n_sub - 1);
  endfunction
endpackage

// File: rtl/dsa_credit_pool.sv
module dsa_credit_pool #(
  parameter int N   = 4,
  parameter int IDW = 2,
  parameter int LIM = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           give_en,
  input  logic [IDW-1:0] give_id,
  input  logic           take_en,
  input  logic [IDW-1:0] take_id,
  output logic [N-1:0]   has_credit,
  output logic [IDW-1:0] last_id
);
  localparam bit UNLIM = (LIM == 0);
  localparam int SHW   = UNLIM ? 16 : $clog2(LIM + 1);
  localparam logic [SHW-1:0] LIM_V = SHW'(LIM);

  logic [N-1:0]   priv_q, priv_mid, priv_nx;
  logic [SHW-1:0] shr_q, shr_mid, shr_nx;
  logic [IDW-1:0] last_q, last_nx;

  // return first, then evaluate credit, then borrow (R5, R4)
  always_comb begin
    priv_mid = priv_q;
    shr_mid  = shr_q;
    if (give_en) begin
      if (priv_mid[give_id]) priv_mid[give_id] = 1'b0;
      else                   shr_mid = shr_mid - 1'b1;
    end
    for (int i = 0; i < N; i++)
      has_credit[i] = !priv_mid[i] || UNLIM || (shr_mid < LIM_V);
    priv_nx = priv_mid;
    shr_nx  = shr_mid;
    last_nx = last_q;
    if (take_en) begin
      if (!priv_mid[take_id]) priv_nx[take_id] = 1'b1;
      else                    shr_nx = shr_mid + 1'b1;
      last_nx = take_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= '0;
      shr_q  <= '0;
      last_q <= IDW'(N - 1);
    end else begin
      priv_q <= priv_nx;
      shr_q  <= shr_nx;
      last_q <= last_nx;
    end
  end

  assign last_id = last_q;
endmodule

// File: rtl/dsa_rr_pick.sv
module dsa_rr_pick #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   elig,
  input  logic [IDW-1:0] last,
  output logic           hit,
  output logic [IDW-1:0] sel
);
  logic [IDW-1:0] idx;
  always_comb begin
    hit = 1'b0;
    sel = '0;
    idx = '0;
    for (int k = 1; k <= N; k++) begin
      idx = IDW'((int'(last) + k) % N);
      if (!hit && elig[idx]) begin
        hit = 1'b1;
        sel = idx;
      end
    end
  end
endmodule

// File: rtl/dsa_delay_line.sv
module dsa_delay_line #(
  parameter int DEPTH = 4,
  parameter int LAT   = 3,
  parameter int W     = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_en,
  input  logic [W-1:0] in_data,
  input  logic         sink_ok,
  output logic         out_en,
  output logic [W-1:0] out_data,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [W-1:0]  data_q [DEPTH];
  logic [TW-1:0] tmr_q  [DEPTH];
  logic [TW-1:0] tmr_nx [DEPTH];
  logic [PW-1:0] rd_q, rd_nx, wr_q, wr_nx;
  logic [CW-1:0] cnt_q, cnt_nx;

  assign full     = (cnt_q == CW'(DEPTH));
  assign out_data = data_q[rd_q];
  assign out_en   = (cnt_q != '0) && (tmr_q[rd_q] == '0) && sink_ok;

  always_comb begin
    rd_nx  = rd_q;
    wr_nx  = wr_q;
    cnt_nx = cnt_q;
    if (out_en) rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (in_en)  wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (in_en && !out_en) cnt_nx = cnt_q + 1'b1;
    else if (!in_en && out_en) cnt_nx = cnt_q - 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      if (in_en && wr_q == PW'(i)) tmr_nx[i] = TW'(LAT - 1);
      else if (tmr_q[i] != '0)     tmr_nx[i] = tmr_q[i] - 1'b1;
      else                         tmr_nx[i] = tmr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) tmr_q[i] <= '0;
    end else begin
      rd_q  <= rd_nx;
      wr_q  <= wr_nx;
      cnt_q <= cnt_nx;
      for (int i = 0; i < DEPTH; i++) tmr_q[i] <= tmr_nx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (in_en) data_q[wr_q] <= in_data;
  end
endmodule

// File: rtl/dram_share_arb.sv
module dram_share_arb #(
  parameter int N_SUB       = 4,
  parameter int SCHED_DEPTH = 2,
  parameter int RETQ_DEPTH  = 2,
  parameter int LAT         = 3,
  parameter int DLY_DEPTH   = 4,
  parameter int PAY_W       = 16,
  parameter int GID_W       = 8,
  parameter int CHAN_ID     = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SUB-1:0]       req_nempty,
  input  logic [N_SUB*PAY_W-1:0] req_payload,
  output logic [N_SUB-1:0]       req_pop,
  input  logic [N_SUB-1:0]       rsp_full,
  output logic [N_SUB-1:0]       rsp_push,
  output logic [PAY_W-1:0]       rsp_data,
  input  logic                   dram_full,
  output logic                   dram_push,
  output logic [GID_W-1:0]       dram_gid,
  output logic [PAY_W-1:0]       dram_data,
  input  logic                   ret_valid,
  input  logic [GID_W-1:0]       ret_gid,
  input  logic                   ret_wb,
  input  logic [PAY_W-1:0]       ret_data,
  output logic                   ret_pop
);
  localparam int IDW = (N_SUB > 1) ? $clog2(N_SUB) : 1;
  localparam int LIM = dsa_pkg::shared_limit(SCHED_DEPTH, RETQ_DEPTH, N_SUB);
  localparam int DW  = IDW + PAY_W;
  localparam logic [GID_W-1:0] BASE = GID_W'(CHAN_ID * N_SUB);

  logic [IDW-1:0] ret_lid, last_id, sel, out_lid;
  logic [N_SUB-1:0] has_credit, elig;
  logic give_en, hit, grant, dly_full;
  logic [DW-1:0] dly_in, dly_out;

  // return routing
  assign ret_lid  = IDW'(ret_gid - BASE);
  assign ret_pop  = ret_valid && !rsp_full[ret_lid];
  assign give_en  = ret_pop && !ret_wb;
  assign rsp_data = ret_data;
  always_comb begin
    rsp_push = '0;
    if (give_en) rsp_push[ret_lid] = 1'b1;
  end

  dsa_credit_pool #(.N(N_SUB), .IDW(IDW), .LIM(LIM)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .give_en(give_en), .give_id(ret_lid),
    .take_en(grant), .take_id(sel),
    .has_credit(has_credit), .last_id(last_id)
  );

  assign elig = req_nempty & has_credit & ~rsp_full;

  dsa_rr_pick #(.N(N_SUB), .IDW(IDW)) u_pick (
    .elig(elig), .last(last_id), .hit(hit), .sel(sel)
  );

  assign grant = hit && !dram_full && !dly_full;
  always_comb begin
    req_pop = '0;
    if (grant) req_pop[sel] = 1'b1;
  end

  assign dly_in = {sel, req_payload[sel*PAY_W +: PAY_W]};

  dsa_delay_line #(.DEPTH(DLY_DEPTH), .LAT(LAT), .W(DW)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .in_en(grant), .in_data(dly_in),
    .sink_ok(!dram_full),
    .out_en(dram_push), .out_data(dly_out),
    .full(dly_full)
  );

  assign out_lid   = dly_out[DW-1:PAY_W];
  assign dram_data = dly_out[PAY_W-1:0];
  assign dram_gid  = BASE + GID_W'(out_lid);
endmodule

// File: rtl/dram_share_arb_chk.sv
module dram_share_arb_chk #(
  parameter int N_SUB   = 4,
  parameter int GID_W   = 8,
  parameter int CHAN_ID = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SUB-1:0] req_nempty,
  input logic [N_SUB-1:0] req_pop,
  input logic [N_SUB-1:0] rsp_full,
  input logic [N_SUB-1:0] rsp_push,
  input logic             dram_full,
  input logic             dram_push,
  input logic             ret_valid,
  input logic [GID_W-1:0] ret_gid,
  input logic             ret_wb,
  input logic             ret_pop
);
  localparam int IDW = (N_SUB > 1) ? $clog2(N_SUB) : 1;
  logic [IDW-1:0] c_lid;
  assign c_lid = IDW'(ret_gid - GID_W'(CHAN_ID * N_SUB));

  a_r6_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_pop));
  a_r7_no_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
    dram_full |-> (req_pop == '0));
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    dram_full |-> !dram_push);
  a_r8_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pop != '0) |-> ((req_pop & ~req_nempty) == '0 && (req_pop & rsp_full) == '0));
  a_r10_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && rsp_full[c_lid]) |-> !ret_pop);
  a_r10_pop_when_room: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !rsp_full[c_lid]) |-> ret_pop);
  a_r10_push_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_push != '0) |-> (ret_pop && rsp_push[c_lid] && $countones(rsp_push) == 1));
  a_r11_wb_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_wb) |-> (rsp_push == '0));
endmodule

bind dram_share_arb dram_share_arb_chk #(.N_SUB(N_SUB), .GID_W(GID_W), .CHAN_ID(CHAN_ID)) u_chk (.*);

// File: tb/dram_share_arb_bench.sv
`timescale 1ns/1ps
module dram_share_arb_bench;
  localparam int N    = 4;
  localparam int SD   = 2;
  localparam int RD   = 2;
  localparam int LAT  = 3;
  localparam int DLY  = 4;
  localparam int PW   = 16;
  localparam int GW   = 8;
  localparam int CH   = 1;
  localparam int LIM  = SD + RD - (N - 1);

  logic clk, rst_n;
  logic [N-1:0] req_nempty, req_pop, rsp_full, rsp_push;
  logic [N*PW-1:0] req_payload;
  logic [PW-1:0] rsp_data, dram_data, ret_data;
  logic dram_full, dram_push, ret_valid, ret_wb, ret_pop;
  logic [GW-1:0] dram_gid, ret_gid;

  dram_share_arb #(.N_SUB(N), .SCHED_DEPTH(SD), .RETQ_DEPTH(RD), .LAT(LAT),
    .DLY_DEPTH(DLY), .PAY_W(PW), .GID_W(GW), .CHAN_ID(CH)) u_dram_share_arb (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit [N-1:0] m_priv;
  int m_sh, m_last, m_now;
  int dq_rdy[$];
  int dq_lid[$];
  logic [PW-1:0] dq_pay[$];

  task automatic chk(bit ok, string tag, logic [31:0] a, logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic bit m_credit(int i);
    return !m_priv[i] || (LIM == 0) || (m_sh < LIM);
  endfunction

  // compare outputs with model, then advance model by one cycle
  task automatic step(string gtag);
    int lid, g;
    bit rpop, rpush, epush;
    logic [N-1:0] epop, erpush;
    lid = int'(ret_gid) - CH * N;
    rpop = ret_valid && !rsp_full[lid];
    rpush = rpop && !ret_wb;
    erpush = '0;
    if (rpush) begin
      erpush[lid] = 1'b1;
      if (m_priv[lid]) m_priv[lid] = 1'b0;
      else if (m_sh > 0) m_sh--;
      else chk(0, "R5 shared count underflow in model", 0, 1);
    end
    epush = (dq_rdy.size() > 0) && (m_now >= dq_rdy[0]) && !dram_full;
    g = -1;
    if (!dram_full && dq_rdy.size() < DLY)
      for (int k = 1; k <= N; k++) begin
        int idx;
        idx = (m_last + k) % N;
        if (g < 0 && req_nempty[idx] && m_credit(idx) && !rsp_full[idx]) g = idx;
      end
    epop = '0;
    if (g >= 0) epop[g] = 1'b1;
    #1;
    chk(req_pop == epop, gtag, 32'(req_pop), 32'(epop));
    chk(dram_push == epush, "R9 dram push timing", 32'(dram_push), 32'(epush));
    if (epush) begin
      chk(dram_gid == GW'(CH * N + dq_lid[0]), "R9 dram gid", 32'(dram_gid), 32'(CH * N + dq_lid[0]));
      chk(dram_data == dq_pay[0], "R9 dram data order", 32'(dram_data), 32'(dq_pay[0]));
    end
    chk(ret_pop == rpop, "R10 return pop", 32'(ret_pop), 32'(rpop));
    chk(rsp_push == erpush, "R10 R11 response push", 32'(rsp_push), 32'(erpush));
    if (rpush) chk(rsp_data == ret_data, "R12 response data", 32'(rsp_data), 32'(ret_data));
    if (g >= 0) begin
      if (!m_priv[g]) m_priv[g] = 1'b1; else m_sh++;
      m_last = g;
    end
    if (epush) begin
      void'(dq_rdy.pop_front()); void'(dq_lid.pop_front()); void'(dq_pay.pop_front());
    end
    if (g >= 0) begin
      dq_rdy.push_back(m_now + LAT);
      dq_lid.push_back(g);
      dq_pay.push_back(req_payload[g*PW +: PW]);
    end
    m_now++;
  endtask

  // choose a return head that never over-returns credit
  task automatic pick_return();
    int s;
    bit ok;
    ret_wb = ($urandom_range(0, 9) < 3);
    s = $urandom_range(0, N - 1);
    ok = ret_wb;
    for (int k = 0; k < N && !ok; k++) begin
      if (m_priv[(s + k) % N] || m_sh > 0) begin s = (s + k) % N; ok = 1; end
    end
    if (!ok) ret_wb = 1'b1;
    ret_gid = GW'(CH * N + s);
    ret_data = PW'($urandom);
  endtask

  task automatic rand_payload();
    for (int i = 0; i < N; i++) req_payload[i*PW +: PW] = PW'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4177));
    m_priv = '0; m_sh = 0; m_last = N - 1; m_now = 0;
    rst_n = 1'b0;
    req_nempty = '0; req_payload = '0; rsp_full = '0; dram_full = 1'b0;
    ret_valid = 1'b0; ret_gid = GW'(CH * N); ret_wb = 1'b0; ret_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(req_pop == '0, "R1 reset grant", 32'(req_pop), 0);
    chk(dram_push == 1'b0, "R1 reset delay line empty", 32'(dram_push), 0);
    chk(ret_pop == 1'b0, "R1 reset return idle", 32'(ret_pop), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // DRAM full: no grant although all request with credit
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      req_nempty = '1; rand_payload(); dram_full = 1'b1;
      step("R7 grant while dram full");
    end
    // first grant after reset goes to 0, then rotation and credit exhaustion
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      req_nempty = '1; rand_payload(); dram_full = 1'b0;
      step(c == 0 ? "R1 first grant to sub 0" : "R2 R3 R4 R6 credit exhaustion grant");
    end
    // destination full: return head must be held
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      rsp_full = '1; ret_valid = 1'b1; pick_return();
      step("R8 grant with response queues full");
    end
    rsp_full = '0; ret_valid = 1'b0;
    // returns only, credit refill then one-at-a-time regrant
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      req_nempty = '1; ret_valid = (c < 6); ret_wb = 1'b0;
      if (c < 6) pick_return();
      if (c < 6) ret_wb = 1'b0;
      if (c < 6 && !(m_priv[int'(ret_gid) - CH * N] || m_sh > 0)) ret_valid = 1'b0;
      step("R5 R4 grant after credit return");
    end
    // constrained random
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      req_nempty = N'($urandom);
      rand_payload();
      for (int i = 0; i < N; i++) rsp_full[i] = ($urandom_range(0, 3) == 0);
      dram_full = ($urandom_range(0, 4) == 0);
      ret_valid = $urandom_range(0, 1);
      pick_return();
      step("R2 R3 R4 R5 R6 R7 R8 random grant");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule